// File: doc/BRIEF.md
# Coherence Invariant Checker

A synthesizable run-time monitor for one tracked cache block in a system where each node keeps a private-cache field and a shared-L2 field. On every strobed sample it receives the encoded state pair of each of N nodes. It tallies how many nodes sit in each of the twelve legal pairs, then applies the protocol's consistency rules to those tallies. A broken rule raises a sticky error flag with a cause code.

The checker looks only at state encodings. It does not compare data and contains no coherence controller. It is placed next to the node controllers, or in an emulation harness, so that any illegal combination of states is caught one cycle after it is shown.

Top module: `coh_inv_checker`

## Requirements
- R1: Each node's state is a 4-bit code at `states_i[4*n +: 4]`. The codes are 0=II, 1=IS2, 2=IM2, 3=IO, 4=S1I, 5=S2I, 6=S2S2, 7=S2O, 8=M1I, 9=M2I, 10=OI, 11=OS2. Field k of `counts_o` (bits `[k*CNT_W +: CNT_W]`, CNT_W = clog2(N+1)) holds the number of nodes reporting code k in the most recent valid sample. It changes one cycle after that sample and holds its value otherwise.
- R2: Any node code from 12 to 15 is an error with cause 1.
- R3: At least one node in M1I or M2I together with at least one node in OS2 is an error with cause 2.
- R4: Two or more nodes in OS2 is an error with cause 3.
- R5: At least one node in IS2 together with at least one node in S2O is an error with cause 4, since the shared-L2 field disagrees between nodes.
- R6: A node in M1I or M2I together with any other node in a pair other than II is an error with cause 5. This includes two exclusive holders.
- R7: When several rules fail in one sample, the lowest cause number is reported.
- R8: `err_o` rises in the cycle after the valid sample that broke a rule. While `valid_i` is low, the states are ignored and the flag cannot rise.
- R9: Once set, `err_o` stays high and `cause_o` keeps the first cause until a clear. Later violations do not change the cause.
- R10: `clear_i` drops the flag and sets the cause to 0. If a violation is sampled in the same cycle, that violation is recorded as the new first error.
- R11: After reset, `err_o` is 0, `cause_o` is 0 and all counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe for `states_i` |
| clear_i | input | 1 | Clears the sticky error |
| states_i | input | N*4 | State code of each node |
| counts_o | output | 12*CNT_W | Number of nodes per state pair |
| err_o | output | 1 | Sticky error flag |
| cause_o | output | 3 | Cause code of the first violation |

## Verification
Directed samples isolate each rule with every other node in II. Each such sample sits next to a near miss that must stay clean, such as a lone M1I holder or a single OS2 owner beside IS2 sharers. Combined samples break several rules at once to separate the priority order. Sticky behaviour is checked by a violation that arrives after an earlier one, and by a clear that lands on a violating sample. Random samples mix legal codes, occasional illegal codes, dropped strobes and clears, and tell apart per-state counting from rule evaluation against a bench model.

// File: rtl/coh_chk_pkg.sv
package coh_chk_pkg;
  localparam int CODE_W  = 4;
  localparam int N_ST    = 12;
  localparam int CAUSE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    ST_II   = 4'd0,  ST_IS2  = 4'd1,  ST_IM2 = 4'd2,  ST_IO   = 4'd3,
    ST_S1I  = 4'd4,  ST_S2I  = 4'd5,  ST_S2S2 = 4'd6, ST_S2O  = 4'd7,
    ST_M1I  = 4'd8,  ST_M2I  = 4'd9,  ST_OI  = 4'd10, ST_OS2  = 4'd11
  } pair_e;

  typedef enum logic [CAUSE_W-1:0] {
    CS_NONE      = 3'd0,
    CS_BAD_CODE  = 3'd1,
    CS_EXCL_OWN  = 3'd2,
    CS_DUAL_OWN  = 3'd3,
    CS_SH_CLASH  = 3'd4,
    CS_SOLE_COPY = 3'd5
  } cause_e;
endpackage

// File: rtl/coh_decode.sv
module coh_decode
  import coh_chk_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*CODE_W-1:0]         states_i,
  output logic [N-1:0][N_ST-1:0]      hot_o,
  output logic [N-1:0]                bad_o
);
  for (genvar g = 0; g < N; g++) begin : g_node
    logic [CODE_W-1:0] code;
    assign code = states_i[g*CODE_W +: CODE_W];
    always_comb begin
      for (int k = 0; k < N_ST; k++) hot_o[g][k] = (code == CODE_W'(k));
      bad_o[g] = (code >= CODE_W'(N_ST));
    end
  end
endmodule

// File: rtl/coh_counter.sv
module coh_counter
  import coh_chk_pkg::*;
#(
  parameter int N     = 4,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0][N_ST-1:0]      hot_i,
  input  logic [N-1:0]                bad_i,
  output logic [N_ST-1:0][CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]            bad_cnt_o
);
  for (genvar k = 0; k < N_ST; k++) begin : g_state
    always_comb begin
      cnt_o[k] = '0;
      for (int n = 0; n < N; n++) cnt_o[k] = cnt_o[k] + CNT_W'(hot_i[n][k]);
    end
  end

  always_comb begin
    bad_cnt_o = '0;
    for (int n = 0; n < N; n++) bad_cnt_o = bad_cnt_o + CNT_W'(bad_i[n]);
  end
endmodule

// File: rtl/coh_rules.sv
module coh_rules
  import coh_chk_pkg::*;
#(
  parameter int N     = 4,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N_ST-1:0][CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]            bad_cnt_i,
  output cause_e                      cause_o
);
  localparam int W = CNT_W + 1;

  logic [W-1:0] excl_cnt;
  logic [W-1:0] active_cnt;
  logic         r_bad, r_excl_own, r_dual_own, r_sh_clash, r_sole;

  assign excl_cnt   = W'(cnt_i[ST_M1I]) + W'(cnt_i[ST_M2I]);
  // nodes with any valid field: not idle, not illegal
  assign active_cnt = W'(N) - W'(cnt_i[ST_II]) - W'(bad_cnt_i);

  assign r_bad      = (bad_cnt_i != '0);
  assign r_excl_own = (excl_cnt != '0) && (cnt_i[ST_OS2] != '0);
  assign r_dual_own = (cnt_i[ST_OS2] >= CNT_W'(2));
  assign r_sh_clash = (cnt_i[ST_IS2] != '0) && (cnt_i[ST_S2O] != '0);
  assign r_sole     = (excl_cnt != '0) && (active_cnt >= W'(2));

  always_comb begin
    if (r_bad)           cause_o = CS_BAD_CODE;
    else if (r_excl_own) cause_o = CS_EXCL_OWN;
    else if (r_dual_own) cause_o = CS_DUAL_OWN;
    else if (r_sh_clash) cause_o = CS_SH_CLASH;
    else if (r_sole)     cause_o = CS_SOLE_COPY;
    else                 cause_o = CS_NONE;
  end
endmodule

// File: rtl/coh_inv_checker.sv
module coh_inv_checker
  import coh_chk_pkg::*;
#(
  parameter int N     = 4,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     clear_i,
  input  logic [N*CODE_W-1:0]      states_i,
  output logic [N_ST*CNT_W-1:0]    counts_o,
  output logic                     err_o,
  output logic [CAUSE_W-1:0]       cause_o
);
  localparam int SUM_W = CNT_W + 4;

  logic [N-1:0][N_ST-1:0]     hot;
  logic [N-1:0]               bad;
  logic [N_ST-1:0][CNT_W-1:0] cnt_d, cnt_q;
  logic [CNT_W-1:0]           bad_cnt;
  cause_e                     cause_d, cause_q;
  logic                       err_q;
  logic                       sample_q, bad_q;
  logic                       viol;

  coh_decode #(.N(N)) u_decode (
    .states_i (states_i),
    .hot_o    (hot),
    .bad_o    (bad)
  );

  coh_counter #(.N(N), .CNT_W(CNT_W)) u_counter (
    .hot_i     (hot),
    .bad_i     (bad),
    .cnt_o     (cnt_d),
    .bad_cnt_o (bad_cnt)
  );

  coh_rules #(.N(N), .CNT_W(CNT_W)) u_rules (
    .cnt_i     (cnt_d),
    .bad_cnt_i (bad_cnt),
    .cause_o   (cause_d)
  );

  assign viol = valid_i && (cause_d != CS_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      err_q    <= 1'b0;
      cause_q  <= CS_NONE;
      sample_q <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      sample_q <= valid_i;
      if (valid_i) begin
        cnt_q <= cnt_d;
        bad_q <= (bad_cnt != '0);
      end
      if (clear_i) begin
        err_q   <= viol;
        cause_q <= viol ? cause_d : CS_NONE;
      end else if (!err_q && viol) begin
        err_q   <= 1'b1;
        cause_q <= cause_d;
      end
    end
  end

  for (genvar k = 0; k < N_ST; k++) begin : g_out
    assign counts_o[k*CNT_W +: CNT_W] = cnt_q[k];
  end
  assign err_o   = err_q;
  assign cause_o = cause_q;

  logic [SUM_W-1:0] cnt_sum;
  always_comb begin
    cnt_sum = '0;
    for (int k = 0; k < N_ST; k++) cnt_sum = cnt_sum + SUM_W'(cnt_q[k]);
  end

  p_count_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_q && !bad_q |-> cnt_sum == SUM_W'(N));

  p_idle_no_raise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o && !valid_i |=> !err_o);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clear_i |=> err_o);

  p_cause_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clear_i |=> $stable(cause_o));

  p_flag_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == (cause_o != CS_NONE));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !valid_i |=> !err_o && cause_o == CS_NONE);
endmodule

// File: tb/coh_inv_checker_bench.sv
`timescale 1ns/1ps
module coh_inv_checker_bench;
  localparam int N     = 4;
  localparam int CW    = 4;
  localparam int NS    = 12;
  localparam int CNT_W = 3;

  localparam logic [3:0] II = 0, IS2 = 1, IM2 = 2, IO = 3, S1I = 4, S2I = 5,
                         S2S2 = 6, S2O = 7, M1I = 8, M2I = 9, OI = 10, OS2 = 11;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  valid_i = 1'b0;
  logic                  clear_i = 1'b0;
  logic [N*CW-1:0]       states_i = '0;
  logic [NS*CNT_W-1:0]   counts_o;
  logic                  err_o;
  logic [2:0]            cause_o;

  int checks = 0;
  int errors = 0;
  logic [NS*CNT_W-1:0] exp_counts = '0;
  logic                exp_err = 1'b0;
  logic [2:0]          exp_cause = 3'd0;

  always #2.5 clk_i = ~clk_i;

  coh_inv_checker #(.N(N)) u_coh_inv_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .clear_i(clear_i),
    .states_i(states_i), .counts_o(counts_o), .err_o(err_o), .cause_o(cause_o)
  );

  function automatic logic [NS*CNT_W-1:0] count_of(logic [N*CW-1:0] st);
    logic [NS*CNT_W-1:0] r = '0;
    for (int n = 0; n < N; n++) begin
      int c = int'(st[n*CW +: CW]);
      if (c < NS) r[c*CNT_W +: CNT_W] = r[c*CNT_W +: CNT_W] + 1'b1;
    end
    return r;
  endfunction

  function automatic logic [2:0] cause_of(logic [N*CW-1:0] st);
    int c[NS];
    int bad = 0;
    int ex;
    for (int k = 0; k < NS; k++) c[k] = 0;
    for (int n = 0; n < N; n++) begin
      int v = int'(st[n*CW +: CW]);
      if (v >= NS) bad++; else c[v]++;
    end
    ex = c[M1I] + c[M2I];
    if (bad > 0) return 3'd1;
    if (ex > 0 && c[OS2] > 0) return 3'd2;
    if (c[OS2] >= 2) return 3'd3;
    if (c[IS2] > 0 && c[S2O] > 0) return 3'd4;
    if (ex > 0 && (N - c[II]) >= 2) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [N*CW-1:0] pk(logic [3:0] a, logic [3:0] b,
                                         logic [3:0] c, logic [3:0] d);
    return {d, c, b, a};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [N*CW-1:0] st, bit v, bit c, string req);
    logic [2:0] cz;
    states_i = st; valid_i = v; clear_i = c;
    cz = v ? cause_of(st) : 3'd0;
    if (v) exp_counts = count_of(st);
    if (c) begin
      exp_err = (cz != 0); exp_cause = cz;
    end else if (!exp_err && cz != 0) begin
      exp_err = 1'b1; exp_cause = cz;
    end
    @(posedge clk_i); #1;
    valid_i = 1'b0; clear_i = 1'b0;
    check(counts_o == exp_counts, req, "counts", int'(counts_o), int'(exp_counts));
    check(err_o == exp_err && cause_o == exp_cause, req, "err/cause",
          {err_o, cause_o}, {exp_err, exp_cause});
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #12;
    // R11 reset state
    check(err_o == 0 && cause_o == 0, "R11", "reset err/cause", {err_o, cause_o}, 0);
    check(counts_o == '0, "R11", "reset counts", int'(counts_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;

    step(pk(II, II, II, II), 1, 0, "R1");            // all idle, clean
    step(pk(M1I, II, II, II), 1, 0, "R6");           // lone holder legal
    step(pk(OS2, IS2, S2S2, IS2), 1, 0, "R4");       // one owner legal
    step(pk(13, 13, 13, 13), 0, 0, "R8");            // ignored without strobe
    step(pk(II, 12, II, II), 1, 0, "R2");
    step(pk(M1I, OS2, II, II), 1, 0, "R9");          // later violation, cause kept
    step(pk(II, II, II, II), 0, 1, "R10");
    step(pk(M1I, OS2, II, II), 1, 0, "R3");
    step(pk(II, II, II, II), 0, 1, "R10");
    step(pk(OS2, OS2, IS2, II), 1, 0, "R4");
    step(pk(IS2, S2O, II, II), 1, 1, "R10");         // clear with new violation
    step(pk(IS2, S2O, II, II), 1, 1, "R5");
    step(pk(M2I, S1I, II, II), 1, 1, "R6");
    step(pk(M1I, M2I, II, II), 1, 1, "R6");
    step(pk(15, M1I, OS2, OS2), 1, 1, "R7");
    step(pk(M1I, OS2, OS2, S2O), 1, 1, "R7");
    step(pk(OS2, OS2, IS2, S2O), 1, 1, "R7");
    step(pk(IS2, S2O, M2I, II), 1, 1, "R7");
    step(pk(II, II, II, II), 1, 1, "R10");
    step(pk(S1I, S2I, S2S2, IO), 1, 0, "R1");
    step(pk(IM2, OI, M2I, II), 0, 0, "R8");          // counts hold, no raise

    for (int i = 0; i < 400; i++) begin
      logic [N*CW-1:0] st;
      for (int n = 0; n < N; n++) begin
        int r = $urandom_range(0, 99);
        if (r < 8)       st[n*CW +: CW] = 4'($urandom_range(12, 15));
        else if (r < 45) st[n*CW +: CW] = II;
        else             st[n*CW +: CW] = 4'($urandom_range(0, 11));
      end
      step(st, $urandom_range(0, 99) < 85, $urandom_range(0, 99) < 30, "R9");
    end

    report();
    $finish;
  end
endmodule